// File: doc/BRIEF.md
# Start-Edge Phase-Locking Byte Receiver

This block receives packets over a byte-wide point-to-point link whose sender runs from its own, unrelated clock. The receiver samples the link with a local clock running at exactly twice the byte rate, so every byte stays on the wires for two sampling periods. One link line doubles as the start line. Between packets it stays high. A packet begins with that line held low for one byte time, and then the payload bytes follow back to back.

Only the start edge is synchronized, through two cascaded stages: a sampling flop, then a set/reset stage that stays set for the whole packet. When the second stage sets, the block records which phase of a free-running half-rate byte clock is current and selects either the true or the inverted byte clock. That choice stays fixed until the packet ends. Every payload byte is then taken once, in the second sample of its two-sample window, with no further phase adjustment. A byte counter is loaded with the packet length. It ends the packet, clears the start stage and re-arms detection.

The output side is a valid-only stream. The link cannot be stalled, so there is no ready input and no back-pressure: the consumer must take every byte in the cycle its strobe is high.

Top module: `link_rx_phase`

## Requirements
- R1: After reset, `byte_valid_o`, `last_o`, `busy_o` and `phase_o` are 0, and the internal byte clock is 0.
- R2: While idle, a low sample of the start line (link bit 7) at a rising clock edge (the start edge, S) sets `busy_o` after the following edge (S+1), so detection passes through two register stages.
- R3: The byte clock resets to 0 and toggles on every edge. At edge S+1, `phase_o` is loaded with the inverse of the byte-clock value before that edge, and it holds that value until the next packet is detected.
- R4: Payload byte k (k from 0) is the link value sampled at edge S+3+2k. It appears on `byte_o` with a one-cycle `byte_valid_o` pulse after that edge, and `byte_o` holds it until the next capture.
- R5: The number of bytes per packet is `pkt_len_i` sampled at edge S+1. A value of 0 counts as 1. Changes to `pkt_len_i` after that edge have no effect on the current packet.
- R6: `last_o` pulses together with the final byte's `byte_valid_o`. `busy_o` falls at that same edge, and a start-line low at the very next edge already starts a new packet.
- R7: While `busy_o` is high, the start line is ordinary payload data. A 0 on it inside a packet neither restarts detection nor shifts the capture phase.
- R8: There is no back-pressure. `byte_valid_o` is never high in two consecutive cycles, and it is never high unless `busy_o` was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, twice the link byte rate |
| rst_n | input | 1 | Active-low synchronous reset |
| link_i | input | 8 | Link lines. Bit 7 also serves as the start line |
| pkt_len_i | input | 6 | Bytes per packet, taken at detection (0 counts as 1) |
| byte_o | output | 8 | Most recently captured payload byte |
| byte_valid_o | output | 1 | One-cycle strobe for a new byte on `byte_o` |
| last_o | output | 1 | Marks the final byte of a packet |
| busy_o | output | 1 | Packet in progress (second start stage set) |
| phase_o | output | 1 | 1 when the inverted byte clock was selected |

## Verification
The bound checker watches properties that hold on every cycle. It checks that strobes are spaced at least two cycles apart and occur only inside a packet, that `last_o` comes with a strobe and with `busy_o` falling, that the selected phase stays constant during a packet, and that no byte is strobed in the cycle right after detection. The exact capture cycle, the byte values, the length sampling and its immunity to later changes, the phase value itself and back-to-back re-arming can only be shown by the bench scenarios. These compare the ports against a behavioural model on every clock. Packets start at random even and odd cycle offsets, so both phase choices get exercised.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;
  localparam int unsigned LINK_W    = 8;
  localparam int unsigned START_BIT = 7;
  localparam int unsigned LEN_W     = 6;

  typedef logic [LINK_W-1:0] link_t;
  typedef logic [LEN_W-1:0]  len_t;

  // a requested length of zero is taken as a single byte
  function automatic len_t eff_len(input len_t req);
    return (req == '0) ? len_t'(1) : req;
  endfunction
endpackage

// File: rtl/rx_start_detect.sv
module rx_start_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic start_line_i,
  input  logic done_i,
  output logic confirm_o,
  output logic active_o
);
  logic stage1_q;
  logic stage2_q;

  // first stage samples the raw line; blind while a packet is open
  always_ff @(posedge clk) begin
    if (!rst_n) stage1_q <= 1'b0;
    else        stage1_q <= ~start_line_i & ~stage2_q;
  end

  assign confirm_o = stage1_q & ~stage2_q;

  // second stage: set by the first, held until the packet completes
  always_ff @(posedge clk) begin
    if (!rst_n)         stage2_q <= 1'b0;
    else if (done_i)    stage2_q <= 1'b0;
    else if (confirm_o) stage2_q <= 1'b1;
  end

  assign active_o = stage2_q;
endmodule

// File: rtl/rx_byte_phase.sv
module rx_byte_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic confirm_i,
  input  logic active_i,
  output logic strobe_o,
  output logic pick_inv_o
);
  logic byte_clk_q;
  logic pick_inv_q;
  logic chosen_clk;

  // free-running half-rate byte clock
  always_ff @(posedge clk) begin
    if (!rst_n) byte_clk_q <= 1'b0;
    else        byte_clk_q <= ~byte_clk_q;
  end

  // lock the phase that will be high two edges from now
  always_ff @(posedge clk) begin
    if (!rst_n)         pick_inv_q <= 1'b0;
    else if (confirm_i) pick_inv_q <= ~byte_clk_q;
  end

  assign chosen_clk = pick_inv_q ? ~byte_clk_q : byte_clk_q;
  assign strobe_o   = active_i & chosen_clk;
  assign pick_inv_o = pick_inv_q;
endmodule

// File: rtl/rx_byte_count.sv
module rx_byte_count
  import link_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  len_t len_i,
  input  logic strobe_i,
  output logic final_o
);
  len_t left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        left_q <= '0;
    else if (load_i)   left_q <= eff_len(len_i);
    else if (strobe_i) left_q <= left_q - len_t'(1);
  end

  assign final_o = strobe_i & (left_q == len_t'(1));
endmodule

// File: rtl/link_rx_phase.sv
module link_rx_phase
  import link_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINK_W-1:0] link_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  output logic [LINK_W-1:0] byte_o,
  output logic             byte_valid_o,
  output logic             last_o,
  output logic             busy_o,
  output logic             phase_o
);
  logic confirm;
  logic active;
  logic strobe;
  logic pick_inv;
  logic final_byte;
  link_t cap_q;
  logic  vld_q;
  logic  last_q;

  rx_start_detect u_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_line_i (link_i[START_BIT]),
    .done_i       (final_byte),
    .confirm_o    (confirm),
    .active_o     (active)
  );

  rx_byte_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .confirm_i  (confirm),
    .active_i   (active),
    .strobe_o   (strobe),
    .pick_inv_o (pick_inv)
  );

  rx_byte_count u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (confirm),
    .len_i    (pkt_len_i),
    .strobe_i (strobe),
    .final_o  (final_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q  <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= strobe;
      last_q <= final_byte;
      if (strobe) cap_q <= link_i;
    end
  end

  assign byte_o       = cap_q;
  assign byte_valid_o = vld_q;
  assign last_o       = last_q;
  assign busy_o       = active;
  assign phase_o      = pick_inv;
endmodule

// File: rtl/link_rx_phase_chk.sv
module link_rx_phase_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_valid_o,
  input logic last_o,
  input logic busy_o,
  input logic phase_o
);
  assert_strobe_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |=> !byte_valid_o);

  assert_strobe_in_packet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> $past(busy_o));

  assert_last_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> (byte_valid_o && !busy_o));

  assert_phase_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(phase_o));

  assert_no_early_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !byte_valid_o);
endmodule

bind link_rx_phase link_rx_phase_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .byte_valid_o (byte_valid_o),
  .last_o       (last_o),
  .busy_o       (busy_o),
  .phase_o      (phase_o)
);

// File: tb/test_link_rx_phase.sv
module test_link_rx_phase;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] link_i = 8'hFF;
  logic [5:0] pkt_len_i = 6'd0;
  logic [7:0] byte_o;
  logic       byte_valid_o, last_o, busy_o, phase_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  link_rx_phase i_link_rx_phase (
    .clk(clk), .rst_n(rst_n), .link_i(link_i), .pkt_len_i(pkt_len_i),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o), .last_o(last_o),
    .busy_o(busy_o), .phase_o(phase_o)
  );

  // behavioural reference model, advanced on every rising edge
  int  edge_no = 0;
  bit  m_open = 0;
  int  m_t = 0;
  int  m_len = 0;
  int  m_got = 0;
  bit  m_busy = 0, m_vld = 0, m_last = 0, m_phase = 0;
  logic [7:0] m_byte = 8'h00;
  logic [7:0] sent_q[$];
  int  recv_n = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      edge_no = 0; m_open = 0; m_busy = 0; m_vld = 0; m_last = 0;
      m_phase = 0; m_byte = 8'h00;
    end else begin
      m_vld = 0; m_last = 0;
      if (!m_open) begin
        if (link_i[7] == 1'b0) begin
          m_open = 1; m_t = 0; m_got = 0;
        end
      end else begin
        m_t++;
        if (m_t == 1) begin
          m_len = (pkt_len_i == 0) ? 1 : int'(pkt_len_i);
          m_phase = ((edge_no % 2) == 0);
        end
        if (m_t >= 3 && ((m_t - 3) % 2) == 0) begin
          m_vld = 1; m_byte = link_i; m_got++;
          if (m_got == m_len) begin m_last = 1; m_open = 0; end
        end
      end
      m_busy = m_open && (m_t >= 1);
      edge_no++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(busy_o == m_busy, "R2 busy", busy_o, m_busy);
      check(byte_valid_o == m_vld, "R4 byte_valid", byte_valid_o, m_vld);
      check(last_o == m_last, "R6 last", last_o, m_last);
      if (m_busy) check(phase_o == m_phase, "R3 phase", phase_o, m_phase);
      if (m_vld) begin
        logic [7:0] want;
        check(byte_o == m_byte, "R4 byte model", byte_o, m_byte);
        want = (sent_q.size() > 0) ? sent_q.pop_front() : 8'hXX;
        check(byte_o === want, "R7 byte sent", byte_o, want);
        recv_n++;
      end
    end
  end

  // sender: start line low for one byte time, then payload bytes
  task automatic send_pkt(input int len_field, input int gap, input bit force_low_start,
                          input int relen_at, input int relen_val);
    int n = (len_field == 0) ? 1 : len_field;
    for (int g = 0; g < gap; g++) begin
      link_i = 8'hFF; @(negedge clk);
    end
    pkt_len_i = 6'(len_field);
    link_i = {1'b0, 7'($urandom)};
    @(negedge clk); @(negedge clk);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b = 8'($urandom);
      if (force_low_start && (k % 2 == 0)) b[7] = 1'b0;
      sent_q.push_back(b);
      link_i = b;
      if (k == relen_at) pkt_len_i = 6'(relen_val);
      @(negedge clk); @(negedge clk);
    end
    link_i = 8'hFF;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(byte_valid_o == 0 && last_o == 0 && busy_o == 0 && phase_o == 0,
          "R1 reset", {byte_valid_o, last_o, busy_o, phase_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 0, "R1 idle after release", busy_o, 0);
    send_pkt(4, 1, 0, -1, 0);          // R2 R4 basic
    send_pkt(3, 2, 0, -1, 0);          // other parity, R3
    send_pkt(0, 3, 0, -1, 0);          // R5 zero means one
    send_pkt(5, 0, 1, -1, 0);          // R6 back to back, R7 low start bit mid-packet
    send_pkt(6, 1, 0, 1, 20);          // R5 length change ignored
    send_pkt(2, 0, 1, -1, 0);          // R6 immediate re-arm
    for (int p = 0; p < 40; p++)
      send_pkt(1 + int'($urandom % 12), int'($urandom % 4), p[0], -1, 0);
    repeat (6) @(negedge clk);
    check(sent_q.size() == 0, "R5 all bytes received once", sent_q.size(), 0);
    check(busy_o == 0, "R6 idle at end", busy_o, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule